// File: doc/BRIEF.md
# 3-D DCT Input Reordering Buffer

This block sits in front of a vector-radix decimation-in-frequency 3-D DCT-II datapath for 4x4x4 cubes. It takes one cube of 64 signed samples in raster order through a valid/ready write port and stores each sample at a folded address. On every axis, even indices go to the lower half of the axis and odd indices go to the upper half in reverse order.

Once the cube is complete, the block streams it out through a valid/ready read port. Planes are visited in a fixed rotated order. Within a plane, rows are emitted in ascending order, and each row's columns follow one of two fixed orders, chosen by the plane step. Each output beat carries the sample, its reordered coordinates, a pass number and an end-of-pass flag.

The downstream arithmetic needs the same cube 2N times, so the whole sequence is replayed for a parameterised number of passes. While the replay is running, the write port is closed.

Top module: `cube_reorder_buf`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Write coordinates come from an internal counter. Sample k has x = k mod 4, z = (k/4) mod 4 and y = k/16. The block accepts exactly 64 samples, and `in_ready` is 0 in the cycle after the 64th accepted write.
- R3: Folding on each axis maps index n to n/2 when n is even and to 3-(n-1)/2 when n is odd. `out_idx` is {plane[5:4], row[3:2], column[1:0]} in folded coordinates. `out_data` is the written sample whose folded (y, z, x) equals that index.
- R4: Within a pass, output beat s (0..63) lies in folded plane 3, 0, 1, 2 for s/16 = 0, 1, 2, 3 respectively.
- R5: Within a plane, the row is (s/4) mod 4. The column for c = s mod 4 follows one of two orders. For plane steps 0 and 2 it is 3, 2, 0, 1. For plane steps 1 and 3 it is 2, 3, 1, 0.
- R6: The 64-beat sequence is emitted PASSES times (8 by default). `out_pass` counts 0 to PASSES-1 and stays constant within a pass.
- R7: `out_last` is 1 exactly on beat 63 of every pass.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output holds its value in the next cycle.
- R9: `in_ready` stays 0 from the end of the fill until the final beat of the last pass is accepted. It is 1 in the next cycle, and writes presented while it is 0 are not stored.
- R10: With `out_ready` held at 1, the first beat is valid one cycle after `in_ready` falls. The remaining beats follow at one per cycle without gaps, so the final beat is accepted 512 cycles after `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write sample offered |
| in_ready | output | 1 | Buffer is filling and takes the sample |
| in_data | input | DATA_W | Signed sample in raster order |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Signed sample in reordered sequence |
| out_idx | output | 6 | Folded {plane, row, column} of the beat |
| out_pass | output | $clog2(PASSES) | Replay pass number |
| out_last | output | 1 | Final beat of the current pass |

## Verification
The bench builds the block with its defaults: 16-bit samples and eight replay passes. With eight passes the pass counter wraps through its full 3-bit range, so the end-of-pass transitions and the reopening of the write port after the eighth pass are both exercised. Three cubes run back to back. The first runs with a free-flowing consumer, to exercise the gap-free timing. The second runs with a pseudo-random stalling consumer, to exercise the hold behaviour. The third uses a gappy writer and offers junk writes during the drain, to show that they are ignored.

// File: rtl/cube_reorder_pkg.sv
package cube_reorder_pkg;
  localparam int SIDE  = 4;
  localparam int AXW   = $clog2(SIDE);
  localparam int CUBE  = SIDE * SIDE * SIDE;
  localparam int AW    = 3 * AXW;

  typedef enum logic [1:0] {ST_FILL, ST_DRAIN, ST_FLUSH} ctl_state_t;

  // even/odd fold of one axis: evens ascend in the low half, odds descend in the high half
  function automatic logic [AXW-1:0] fold_axis(input logic [AXW-1:0] n);
    if (!n[0]) return n >> 1;
    else       return AXW'(SIDE - 1) - (n >> 1);
  endfunction

  // plane visited at a given step of a pass: top plane first, then ascending
  function automatic logic [AXW-1:0] plane_at(input logic [AXW-1:0] step);
    if (step == '0) return AXW'(SIDE - 1);
    else            return step - 1'b1;
  endfunction

  // column order inside a row; the parity of the plane step picks the variant
  function automatic logic [AXW-1:0] col_at(input logic odd_step, input logic [AXW-1:0] c);
    logic [AXW-1:0] r;
    if (!odd_step) begin
      case (c)
        2'd0: r = 2'd3;
        2'd1: r = 2'd2;
        2'd2: r = 2'd0;
        default: r = 2'd1;
      endcase
    end else begin
      case (c)
        2'd0: r = 2'd2;
        2'd1: r = 2'd3;
        2'd2: r = 2'd1;
        default: r = 2'd0;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/cube_wr_seq.sv
module cube_wr_seq
  import cube_reorder_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  output logic [AW-1:0] wr_addr,
  output logic          wr_last
);
  logic [AW-1:0]  cnt_q;
  logic [AXW-1:0] ax_x, ax_y, ax_z;

  assign ax_x = cnt_q[AXW-1:0];
  assign ax_z = cnt_q[2*AXW-1:AXW];
  assign ax_y = cnt_q[3*AXW-1:2*AXW];

  assign wr_addr = {fold_axis(ax_y), fold_axis(ax_z), fold_axis(ax_x)};
  assign wr_last = (cnt_q == AW'(CUBE - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (fire) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cube_rd_seq.sv
module cube_rd_seq
  import cube_reorder_pkg::*;
#(
  parameter  int PASSES = 8,
  localparam int PW     = $clog2(PASSES)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_pass,
  output logic          rd_last,
  output logic          rd_final
);
  logic [AW-1:0]  seq_q;
  logic [PW-1:0]  pass_q;
  logic [AXW-1:0] step, row, col;

  assign step = seq_q[3*AXW-1:2*AXW];
  assign row  = seq_q[2*AXW-1:AXW];
  assign col  = seq_q[AXW-1:0];

  assign rd_addr  = {plane_at(step), row, col_at(step[0], col)};
  assign rd_pass  = pass_q;
  assign rd_last  = (seq_q == AW'(CUBE - 1));
  assign rd_final = rd_last && (pass_q == PW'(PASSES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= '0;
      pass_q <= '0;
    end else if (adv) begin
      seq_q <= seq_q + 1'b1;
      if (rd_last) pass_q <= rd_final ? '0 : pass_q + 1'b1;
    end
  end
endmodule

// File: rtl/cube_store.sv
module cube_store #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 64,
  localparam int AW     = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cube_reorder_buf.sv
module cube_reorder_buf
  import cube_reorder_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int PASSES = 8,
  localparam int PW     = $clog2(PASSES)
)(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  output logic [AW-1:0]            out_idx,
  output logic [PW-1:0]            out_pass,
  output logic                     out_last
);
  ctl_state_t        state_q;
  logic              ov_q, last_q;
  logic [DATA_W-1:0] data_q, mem_rd;
  logic [AW-1:0]     idx_q, wr_addr, rd_addr;
  logic [PW-1:0]     pass_q, rd_pass;
  logic              wr_last, rd_last, rd_final;
  logic              wr_fire, load, issue;

  assign wr_fire = in_valid && (state_q == ST_FILL);
  assign load    = !ov_q || out_ready;
  assign issue   = (state_q == ST_DRAIN) && load;

  cube_wr_seq u_wr (
    .clk(clk), .rst(rst), .fire(wr_fire),
    .wr_addr(wr_addr), .wr_last(wr_last)
  );

  cube_rd_seq #(.PASSES(PASSES)) u_rd (
    .clk(clk), .rst(rst), .adv(issue),
    .rd_addr(rd_addr), .rd_pass(rd_pass), .rd_last(rd_last), .rd_final(rd_final)
  );

  cube_store #(.DATA_W(DATA_W), .DEPTH(CUBE)) u_mem (
    .clk(clk), .we(wr_fire), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(mem_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FILL;
      ov_q    <= 1'b0;
      data_q  <= '0;
      idx_q   <= '0;
      pass_q  <= '0;
      last_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_FILL:  if (wr_fire && wr_last) state_q <= ST_DRAIN;
        ST_DRAIN: if (issue && rd_final)  state_q <= ST_FLUSH;
        ST_FLUSH: if (ov_q && out_ready)  state_q <= ST_FILL;
        default:  state_q <= ST_FILL;
      endcase
      if (issue) begin
        ov_q   <= 1'b1;
        data_q <= mem_rd;
        idx_q  <= rd_addr;
        pass_q <= rd_pass;
        last_q <= rd_last;
      end else if (load) begin
        ov_q <= 1'b0;
      end
    end
  end

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = ov_q;
  assign out_data  = data_q;
  assign out_idx   = idx_q;
  assign out_pass  = pass_q;
  assign out_last  = last_q;

  // R8: a stalled beat is held unchanged
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx)
                                && $stable(out_pass) && $stable(out_last));

  // R9: write side and read side never active together
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R9: port reopens right after the last beat of the last pass
  p_reopen_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last && out_pass == PW'(PASSES - 1)
    |=> in_ready && !out_valid);

  // R6: pass number constant inside a pass
  p_pass_keep_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> out_valid && out_pass == $past(out_pass));

  // R7: end-of-pass beat is followed by the next pass
  p_pass_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last && out_pass != PW'(PASSES - 1)
    |=> out_valid && out_pass == PW'($past(out_pass) + 1'b1) && !out_last);

  // R2: write port closes after the 64th write
  p_fill_close_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && wr_last |=> !in_ready && !out_valid);

  // R10: first beat one cycle after the fill ends
  p_first_beat_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |=> out_valid && out_pass == '0);
endmodule

// File: tb/cube_reorder_buf_test.sv
module cube_reorder_buf_test;
  localparam int DW = 16;
  localparam int NP = 8;

  typedef struct packed {
    logic [DW-1:0] d;
    logic [5:0]    i;
    logic [2:0]    p;
    logic          l;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic signed [DW-1:0] out_data;
  logic [5:0] out_idx;
  logic [2:0] out_pass;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cube_reorder_buf #(.DATA_W(DW), .PASSES(NP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_idx(out_idx), .out_pass(out_pass), .out_last(out_last)
  );

  // model state
  bit mfill = 1;
  int wcnt = 0;
  logic signed [DW-1:0] cube [64];
  exp_t q[$];
  int cyc = 0, t0 = 0, cube_no = 0;
  bit rmode = 0, vmode = 0, cube_done = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit pv = 0, pr = 0, pl = 0;
  logic [DW-1:0] pd = '0;
  logic [5:0] pi = '0;
  logic [2:0] pp = '0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int tb_fold(input int n);
    return (n % 2 == 0) ? n / 2 : 3 - (n - 1) / 2;
  endfunction

  function automatic int unfold(input int v);
    for (int n = 0; n < 4; n++) if (tb_fold(n) == v) return n;
    return 0;
  endfunction

  function automatic logic signed [DW-1:0] sample(input int c, input int k);
    return DW'(c * 4099 + k * 977 - 30000);
  endfunction

  task automatic build_queue();
    int ord0 [4] = '{3, 2, 0, 1};
    int ord1 [4] = '{2, 3, 1, 0};
    exp_t e;
    for (int p = 0; p < NP; p++) begin
      for (int s = 0; s < 64; s++) begin
        int st = s / 16;
        int rw = (s / 4) % 4;
        int cl = s % 4;
        int py = (st == 0) ? 3 : st - 1;
        int px = (st % 2 == 0) ? ord0[cl] : ord1[cl];
        e.d = cube[unfold(py) * 16 + unfold(rw) * 4 + unfold(px)];
        e.i = 6'(py * 16 + rw * 4 + px);
        e.p = 3'(p);
        e.l = (s == 63);
        q.push_back(e);
      end
    end
  endtask

  task automatic step();
    exp_t e;
    bit acc;
    @(negedge clk);
    check(in_ready === mfill, "R9", "in_ready", int'(in_ready), int'(mfill));
    if (pv && !pr) begin
      check(out_valid === 1'b1, "R8", "valid held", int'(out_valid), 1);
      check(out_data === pd && out_idx === pi && out_pass === pp && out_last === pl,
            "R8", "held data", int'(out_data), int'($signed(pd)));
    end
    if (out_valid && q.size() == 0)
      check(0, "R6", "beat outside a replay", 1, 0);
    // drive this cycle's inputs
    if (mfill) begin
      in_valid = vmode ? (cyc % 3 != 1) : 1'b1;
      in_data  = sample(cube_no, wcnt);
    end else begin
      in_valid = (cyc % 2 == 0);
      in_data  = DW'(16'h5A5A ^ cyc);
    end
    out_ready = rmode ? lfsr[0] : 1'b1;
    acc = out_valid && out_ready;
    // writer model uses the state before this edge
    if (mfill && in_valid) begin
      cube[wcnt] = in_data;
      wcnt++;
      if (wcnt == 64) begin
        wcnt = 0;
        mfill = 0;
        t0 = cyc + 1;
        build_queue();
      end
    end
    if (acc && q.size() > 0) begin
      e = q.pop_front();
      check(out_data === e.d, "R3", "data", int'(out_data), int'($signed(e.d)));
      check(out_idx === e.i, "R4", "idx (R5 order)", int'(out_idx), int'(e.i));
      check(out_pass === e.p, "R6", "pass", int'(out_pass), int'(e.p));
      check(out_last === e.l, "R7", "last", int'(out_last), int'(e.l));
      if (e.l && e.p == 3'(NP - 1)) begin
        mfill = 1;
        cube_done = 1;
        if (!rmode) check(cyc - t0 == 512, "R10", "drain cycles", cyc - t0, 512);
      end
    end
    pv = out_valid; pr = out_ready; pd = out_data; pi = out_idx; pp = out_pass; pl = out_last;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    cyc++;
  endtask

  task automatic run_cube(input int c, input bit rm, input bit vm);
    cube_no = c; rmode = rm; vmode = vm; cube_done = 0;
    while (!cube_done) step();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    run_cube(1, 1'b0, 1'b0);   // R10 free-flowing consumer, R2 full fill
    run_cube(2, 1'b1, 1'b0);   // R8 stalling consumer
    run_cube(3, 1'b1, 1'b1);   // R9 gappy writer, junk writes during drain
    repeat (3) step();
    check(q.size() == 0, "R6", "beats left over", q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R6 watchdog expired: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule